// File: doc/BRIEF.md
# Latency-Slotted Writeback Queue

This block schedules result writeback for a microcode engine with an exposed pipeline and a 128-entry general register file. Each cycle the current instruction word is split into two source register numbers, an opcode and a destination register number. The execution units, which are modelled outside this block, return a result value for the opcode in the same cycle. That value is parked in a seven-entry circular slot ring. Its position is set by the opcode's latency, so it reaches the ring head exactly that many issue cycles later.

Every issuing cycle, the value at the ring head is written to the register named by the destination field of the instruction issuing in that cycle, not of the instruction that produced the value. The head slot is then emptied and the head moves on one place. The microcode must therefore arrange for the consuming instruction to sit at the right distance from its producer. A vector-output instruction marks the end of a run: it leaves the ring and the registers untouched and raises a one-cycle end flag. Source operands are read combinationally from the register file and show its contents from before the writeback of that same cycle.

Top module: `wbq_sched`

## Requirements
- R1: The 25-bit instruction word carries source A in bits 24:18, source B in bits 17:11, the opcode in bits 10:7 and the destination in bits 6:0. `src_a_val` and `src_b_val` show the registers named by the two source fields whether or not `issue_valid` is high.
- R2: Opcode encodings and their latencies: 0 no-op (none), 1 add (5), 2 subtract (5), 3 multiply (7), 4 absolute (2), 5 float-to-int (2), 6 int-to-float (3), 7 vector-output (none), 8 sine (4), 9 cosine (4), 10 greater-than (2), 11 equal (2), 12 copy (2), 13 select (2), 14 sign-transfer (2), 15 reciprocal-root seed (2). A result issued in issue cycle n appears on `wb_data` in issue cycle n+latency.
- R3: In an issuing cycle whose destination field is nonzero, `wb_en` is high, `wb_addr` equals that field, and the head value is written to that register. A destination of 0 writes nothing.
- R4: In each issuing cycle the head slot is emptied to zero and the head advances by one, wrapping after seven slots, so a slot that is consumed and not refilled reads zero seven issue cycles later.
- R5: A no-op advances the ring and may write back, but places nothing into the ring.
- R6: A vector-output instruction (opcode 7) with `issue_valid` high raises `run_end` for that cycle, writes no register and neither reads nor advances the ring.
- R7: With `issue_valid` low the ring, the head position and the registers hold their state and `wb_en` stays low.
- R8: Reset empties all seven slots, returns the head to slot 0 and clears all 128 registers.
- R9: When a latency-7 result is issued, its target slot is the one being emptied in that same cycle, and the new result takes the slot.
- R10: Within one issuing cycle, the source values reflect the register file from before that cycle's writeback, even when a source field names the destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| insn | input | 25 | Instruction word |
| exec_result | input | 32 | Result returned by the execution units for the current opcode |
| src_a_val | output | 32 | Register named by the source A field |
| src_b_val | output | 32 | Register named by the source B field |
| wb_en | output | 1 | Writeback to the register file this cycle |
| wb_addr | output | 7 | Writeback register number |
| wb_data | output | 32 | Value at the ring head |
| run_end | output | 1 | A vector-output instruction issues this cycle |

## Verification
In one issuing cycle the ring head is read and emptied, and a new result is inserted. For a latency-7 opcode both land on the same slot. The bench provokes this by issuing a multiply, letting six no-ops pass, and then expecting the multiply's value on `wb_data`, not zero. Seven issue cycles after that, the same slot must read zero again. Writeback and operand reads also fall in the same cycle: vectors whose source field equals their destination must show the old register value, and a later readback must show the new one.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  localparam int REG_AW = 7;
  localparam int OP_W   = 4;
  localparam int INSN_W = 3 * REG_AW + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_MUL = 4'd3,
    OP_ABS  = 4'd4,  OP_F2I = 4'd5,  OP_I2F = 4'd6,  OP_VOUT = 4'd7,
    OP_SIN  = 4'd8,  OP_COS = 4'd9,  OP_GT  = 4'd10, OP_EQ  = 4'd11,
    OP_MOV  = 4'd12, OP_SEL = 4'd13, OP_SGN = 4'd14, OP_RSQ = 4'd15
  } op_e;

  typedef struct packed {
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
    op_e               op;
    logic [REG_AW-1:0] dst;
  } fields_t;

  // Issue cycles between issue and appearance at the ring head.
  function automatic int unsigned op_latency(op_e op);
    case (op)
      OP_MUL:                 return 7;
      OP_ADD, OP_SUB:         return 5;
      OP_SIN, OP_COS:         return 4;
      OP_I2F:                 return 3;
      OP_NOP, OP_VOUT:        return 0;
      default:                return 2;
    endcase
  endfunction

  // Slot index that reaches the head 'lat' steps after 'head'.
  function automatic int unsigned ring_slot(int unsigned head, int unsigned lat,
                                            int unsigned n);
    return (head + lat) % n;
  endfunction
endpackage

// File: rtl/wbq_decode.sv
module wbq_decode
  import wbq_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output fields_t           fld
);
  // R1: field positions fixed by the encoding
  always_comb begin
    fld.src_a = insn[24:18];
    fld.src_b = insn[17:11];
    fld.op    = op_e'(insn[10:7]);
    fld.dst   = insn[6:0];
  end
endmodule

// File: rtl/wbq_slot_ring.sv
module wbq_slot_ring #(
  parameter int SLOTS = 7,
  parameter int DW    = 32,
  localparam int HW   = $clog2(SLOTS),
  localparam int LATW = $clog2(SLOTS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            ins_en,
  input  logic [LATW-1:0] ins_lat,
  input  logic [DW-1:0]   ins_data,
  output logic [DW-1:0]   head_data
);
  logic [DW-1:0] slot_q [SLOTS];
  logic [HW-1:0] head_q;
  logic [HW-1:0] head_nxt;
  logic [HW-1:0] ins_idx;

  always_comb begin
    head_nxt  = (int'(head_q) == SLOTS - 1) ? '0 : head_q + 1'b1;
    ins_idx   = HW'(wbq_pkg::ring_slot(int'(head_q), int'(ins_lat), SLOTS));
    head_data = slot_q[head_q];
  end

  // Clear first, insert second: insertion wins when both hit one slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
      head_q <= '0;
    end else if (step) begin
      slot_q[head_q] <= '0;
      if (ins_en) slot_q[ins_idx] <= ins_data;
      head_q <= head_nxt;
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(head_q));
  // R4
  head_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !(ins_en && ins_idx == head_q) |=> slot_q[$past(head_q)] == '0);
  // R9
  insert_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && ins_en |=> slot_q[$past(ins_idx)] == $past(ins_data));
endmodule

// File: rtl/wbq_regfile.sv
module wbq_regfile #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] mem [DEPTH];

  // Reads see the state before this cycle's write (R10).
  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // R3
  wb_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/wbq_sched.sv
module wbq_sched
  import wbq_pkg::*;
#(
  parameter int SLOTS = 7,
  parameter int DW    = 32,
  localparam int LATW = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [DW-1:0]     exec_result,
  output logic [DW-1:0]     src_a_val,
  output logic [DW-1:0]     src_b_val,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_addr,
  output logic [DW-1:0]     wb_data,
  output logic              run_end
);
  fields_t         fld;
  logic            issue_step;
  logic            ins_en;
  logic [LATW-1:0] ins_lat;

  wbq_decode u_dec (.insn(insn), .fld(fld));

  always_comb begin
    run_end    = issue_valid && (fld.op == OP_VOUT);
    issue_step = issue_valid && (fld.op != OP_VOUT);
    ins_en     = issue_step && (fld.op != OP_NOP);
    ins_lat    = LATW'(op_latency(fld.op));
    wb_en      = issue_step && (fld.dst != '0);
    wb_addr    = fld.dst;
  end

  wbq_slot_ring #(.SLOTS(SLOTS), .DW(DW)) u_ring (
    .clk(clk), .rst_n(rst_n), .step(issue_step), .ins_en(ins_en),
    .ins_lat(ins_lat), .ins_data(exec_result), .head_data(wb_data)
  );

  wbq_regfile #(.DEPTH(1 << REG_AW), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra_a(fld.src_a), .ra_b(fld.src_b),
    .rd_a(src_a_val), .rd_b(src_b_val),
    .we(wb_en), .waddr(wb_addr), .wdata(wb_data)
  );

  // R6
  vout_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_end |-> !wb_en);
  // R7
  idle_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> !wb_en && !run_end);
  initial begin
    assert (SLOTS >= 7) else $error("ring shorter than longest latency");
  end
endmodule

// File: tb/wbq_sched_tb.sv
module wbq_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [24:0] insn = '0;
  logic [31:0] exec_result = '0;
  logic [31:0] src_a_val, src_b_val, wb_data;
  logic        wb_en, run_end;
  logic [6:0]  wb_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wbq_sched dut_i (.*);

  always #2.5 clk = ~clk;

  function automatic logic [24:0] mk(int sa, int sb, int op, int dst);
    return {7'(sa), 7'(sb), 4'(op), 7'(dst)};
  endfunction

  localparam int LAT_T [16] = '{0,5,5,7,2,2,3,0,4,4,2,2,2,2,2,2};

  localparam int NV = 21;
  localparam logic [24:0] V_INSN [NV] = '{
    mk(3,4,1,0),    mk(5,6,3,0),    mk(0,0,12,0),  mk(1,2,6,5),
    mk(5,5,0,20),   mk(20,21,5,21), mk(21,20,0,22), mk(22,0,2,23),
    mk(23,22,11,24), mk(24,0,0,25), mk(26,24,0,26), mk(26,0,14,0),
    mk(0,26,0,27),  mk(27,0,0,28),  mk(28,27,9,0),  mk(0,0,15,0),
    mk(0,0,0,29),   mk(29,0,0,30),  mk(30,29,13,31), mk(31,0,0,32),
    mk(32,31,0,33)};
  localparam logic [31:0] V_RES [NV] = '{
    32'hA1A1_0001, 32'hB2B2_0002, 32'hC3C3_0003, 32'hD4D4_0004,
    32'h0, 32'hE5E5_0005, 32'h0, 32'h1717_0007, 32'h1818_0008, 32'h0,
    32'h0, 32'h1919_0009, 32'h0, 32'h0, 32'h1A1A_000A, 32'h1B1B_000B,
    32'h0, 32'h0, 32'h1C1C_000C, 32'h0, 32'h0};

  // Independent model: results keyed by absolute issue count.
  logic [31:0] mq [64];
  logic [31:0] mrf [128];
  int n_iss = 0;

  task automatic model_clear();
    for (int i = 0; i < 64; i++) mq[i] = '0;
    for (int i = 0; i < 128; i++) mrf[i] = '0;
    n_iss = 0;
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [24:0] w, logic [31:0] res, string tag);
    int sa = int'(w[24:18]);
    int sb = int'(w[17:11]);
    int op = int'(w[10:7]);
    int dst = int'(w[6:0]);
    bit vout = (op == 7);
    bit en_exp = !vout && dst != 0;
    @(negedge clk);
    issue_valid = 1'b1; insn = w; exec_result = res;
    #1;
    chk(src_a_val == mrf[sa], {tag, " srcA"}, src_a_val, mrf[sa]);
    chk(src_b_val == mrf[sb], {tag, " srcB"}, src_b_val, mrf[sb]);
    chk(wb_en == en_exp, {tag, " wb_en"}, 32'(wb_en), 32'(en_exp));
    chk(run_end == vout, {tag, " run_end"}, 32'(run_end), 32'(vout));
    if (!vout) begin
      chk(wb_data == mq[n_iss % 64], {tag, " wb_data"}, wb_data, mq[n_iss % 64]);
      if (en_exp) chk(wb_addr == 7'(dst), {tag, " wb_addr"}, 32'(wb_addr), 32'(dst));
      if (dst != 0) mrf[dst] = mq[n_iss % 64];
      mq[n_iss % 64] = '0;
      if (op != 0) mq[(n_iss + LAT_T[op]) % 64] = res;
      n_iss++;
    end
  endtask

  task automatic rd(int ra, int rb, string tag);
    @(negedge clk);
    issue_valid = 1'b0; insn = mk(ra, rb, 0, 0);
    #1;
    chk(src_a_val == mrf[ra], tag, src_a_val, mrf[ra]);
    chk(src_b_val == mrf[rb], tag, src_b_val, mrf[rb]);
    chk(!wb_en && !run_end, {tag, " idle"}, 32'({wb_en, run_end}), 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    model_clear();
    do_reset();
    // R8: reset state
    #1;
    chk(wb_data == 32'h0, "R8 head after reset", wb_data, 32'h0);
    rd(5, 20, "R8 regs after reset");

    // R1 R2 R3 R5 R10: vector table
    for (int k = 0; k < NV; k++) issue(V_INSN[k], V_RES[k], "R2 vec");
    for (int r = 20; r < 34; r += 2) rd(r, r + 1, "R1 readback");
    rd(5, 21, "R10 readback");

    // R6: vector-output leaves ring and regs alone
    issue(mk(0,0,1,0), 32'h0BAD_0001, "R6 prep");
    issue(mk(0,0,7,40), 32'hFFFF_FFFF, "R6 vout");
    for (int k = 0; k < 5; k++) issue(mk(0,0,0,41 + k), 32'h0, "R6 after");
    rd(40, 45, "R6 regs");

    // R7: idle cycles
    issue(mk(0,0,12,0), 32'h7777_0007, "R7 prep");
    for (int k = 0; k < 3; k++) rd(0, 0, "R7 idle");
    issue(mk(0,0,0,46), 32'h0, "R7 resume");
    issue(mk(0,0,0,47), 32'h0, "R7 land");
    rd(46, 47, "R7 regs");

    // R9 and R4: latency-7 insert into slot being cleared
    issue(mk(0,0,3,0), 32'hCAFE_0007, "R9 mul");
    for (int k = 0; k < 6; k++) issue(mk(0,0,0,0), 32'h0, "R9 wait");
    issue(mk(0,0,0,50), 32'h0, "R9 land");
    for (int k = 0; k < 6; k++) issue(mk(0,0,0,0), 32'h0, "R4 wait");
    issue(mk(0,0,0,51), 32'h0, "R4 empty slot");
    rd(50, 51, "R9 R4 regs");
    issue(mk(50,0,0,0), 32'h0, "R5 nop");

    // R8: reset mid-run drops pending results
    issue(mk(0,0,4,0), 32'hDEAD_0004, "R8 prep");
    do_reset();
    #1;
    chk(wb_data == 32'h0, "R8 head", wb_data, 32'h0);
    rd(50, 46, "R8 regs");
    for (int k = 0; k < 7; k++) issue(mk(0,0,0,52), 32'h0, "R8 ring empty");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule